// File: doc/BRIEF.md
# Wake Event Request Controller

This block gathers wake-up indications from a network interface and turns them into a power-management request toward the host. It watches three sources: a magic-packet detector, a pattern-match detector and the link-up state of the PHY. It converts each source into a single-cycle event. It drops events that are not valid in the current interface mode. Every event that survives sets a sticky status flag.

The host reaches the block through a small configuration read/write port. One register sits at configuration address 0x44. It holds a request-enable bit and the sticky status flag. The request line is active low and is intended to drive an open-drain pad. It is pulled low only while both the enable bit and the status flag are set. Host software scans the status flag to find out which device asked for wake-up, then clears it by writing a one to it.

Top module: `wake_evt_ctrl`

## Requirements
- R1: After a synchronous reset, the enable bit and the status flag are 0, `pme_n` is 1, and a read of address 0x44 returns 0.
- R2: The register at address 0x44 reads back as {16'b0, status at bit 15, 6'b0, enable at bit 8, 8'b0}. A write to 0x44 loads the enable bit from bit 8 of the write data. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: A rising edge on `magic_det` sets the status flag in either interface mode. A level held high does not set the flag again, and a falling edge sets nothing.
- R4: A rising edge on `pattern_det` sets the status flag only while `mii_mode` is 1. When `mii_mode` is 0 it has no effect.
- R5: A toggle of `link_up` in either direction sets the status flag only while `mii_mode` is 1. When `mii_mode` is 0 it has no effect.
- R6: The status flag stays set until a write to 0x44 carries a 1 in bit 15. A write with bit 15 at 0 leaves the flag unchanged.
- R7: If a qualified event and a clearing write are taken in the same clock cycle, the status flag ends up set.
- R8: `pme_n` is a registered output. It is 0 exactly one cycle after enable and status are both 1, and it is 1 otherwise. While the enable bit is 0, the status flag still sets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| magic_det | input | 1 | Magic-packet detector output (level, edge-detected inside) |
| pattern_det | input | 1 | Pattern-match detector output (level, edge-detected inside) |
| link_up | input | 1 | PHY link-up state; any toggle is an event |
| mii_mode | input | 1 | 1 when the MII interface is in use |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read data, valid the cycle after `cfg_rd` |
| pme_n | output | 1 | Active-low wake request toward an open-drain pad |

## Verification
A new wake event and a software clear of the status flag can land in the same clock cycle. The bench provokes this by first setting the flag, then raising `magic_det`, and issuing the clearing write on the very edge at which the internal event pulse is present. It judges the result by reading 0x44 afterwards and expecting bit 15 still set. The other cases covered are clears without a competing event and writes with bit 15 at 0, so a design that lets the clear win, or that clears on any write, is reported.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int unsigned NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_MAGIC   = 2'd0,
    SRC_PATTERN = 2'd1,
    SRC_LINK    = 2'd2
  } wake_src_e;

  // Source may only raise an event while the MII interface is selected.
  function automatic bit src_needs_mii(input int unsigned idx);
    return (idx == int'(SRC_PATTERN)) || (idx == int'(SRC_LINK));
  endfunction

  // Source reports on any change instead of only on a rising edge.
  function automatic bit src_on_toggle(input int unsigned idx);
    return idx == int'(SRC_LINK);
  endfunction

endpackage

// File: rtl/wake_evt_qual.sv
module wake_evt_qual
  import wake_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] src_lvl,
  input  logic             mii_mode,
  output logic [N_SRC-1:0] src_pulse,
  output logic             any_evt
);

  logic             mii_q;
  logic [N_SRC-1:0] stage1_q;
  logic [N_SRC-1:0] stage2_q;
  logic [N_SRC-1:0] qual;

  always_ff @(posedge clk) begin
    if (rst) begin
      mii_q <= 1'b0;
    end else begin
      mii_q <= mii_mode;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1_q[g] <= 1'b0;
        stage2_q[g] <= 1'b0;
      end else begin
        stage1_q[g] <= src_lvl[g];
        stage2_q[g] <= stage1_q[g];
      end
    end

    if (src_on_toggle(g)) begin : g_toggle
      assign src_pulse[g] = stage1_q[g] ^ stage2_q[g];
    end else begin : g_rise
      assign src_pulse[g] = stage1_q[g] & ~stage2_q[g];
    end

    if (src_needs_mii(g)) begin : g_gated
      assign qual[g] = src_pulse[g] & mii_q;
    end else begin : g_open
      assign qual[g] = src_pulse[g];
    end
  end

  assign any_evt = |qual;

  // R3: an edge-detected magic strobe lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    src_pulse[SRC_MAGIC] |=> !src_pulse[SRC_MAGIC]);

endmodule

// File: rtl/wake_pm_csr.sv
module wake_pm_csr #(
  parameter int unsigned          ADDR_W   = 8,
  parameter int unsigned          DATA_W   = 32,
  parameter logic [ADDR_W-1:0]    CSR_ADDR = 8'h44,
  parameter int unsigned          EN_BIT   = 8,
  parameter int unsigned          ST_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              evt,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pme_en,
  output logic              pme_st
);

  logic              hit;
  logic              wr_hit;
  logic              clr_hit;
  logic [DATA_W-1:0] csr_view;
  logic              wdata_unused;

  assign hit          = (cfg_addr == CSR_ADDR);
  assign wr_hit       = cfg_wr & hit;
  assign clr_hit      = wr_hit & cfg_wdata[ST_BIT];
  assign wdata_unused = ^cfg_wdata;

  always_comb begin
    csr_view         = '0;
    csr_view[EN_BIT] = pme_en;
    csr_view[ST_BIT] = pme_st;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_en <= 1'b0;
    end else if (wr_hit) begin
      pme_en <= cfg_wdata[EN_BIT];
    end
  end

  // Event has priority over a clear taken on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      pme_st <= 1'b0;
    end else begin
      pme_st <= evt | (pme_st & ~clr_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else if (cfg_rd) begin
      cfg_rdata <= hit ? csr_view : '0;
    end
  end

  // R1: reset leaves enable and status clear
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!pme_en && !pme_st));

  // R2: a write to the register loads the enable bit
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    wr_hit |=> (pme_en == $past(cfg_wdata[EN_BIT])));

  // R6: without a clearing write the flag holds
  a_r6_status_sticky: assert property (@(posedge clk) disable iff (rst)
    (pme_st && !clr_hit) |=> pme_st);

  // R7: an event always leaves the flag set, clear or not
  a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
    evt |=> pme_st);

endmodule

// File: rtl/wake_evt_ctrl.sv
module wake_evt_ctrl
  import wake_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter int unsigned       DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h44,
  parameter int unsigned       EN_BIT   = 8,
  parameter int unsigned       ST_BIT   = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              magic_det,
  input  logic              pattern_det,
  input  logic              link_up,
  input  logic              mii_mode,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              pme_n
);

  logic [NUM_SRC-1:0] src_lvl;
  logic [NUM_SRC-1:0] src_pulse;
  logic               any_evt;
  logic               csr_en;
  logic               csr_st;
  logic               pulse_unused;

  always_comb begin
    src_lvl              = '0;
    src_lvl[SRC_MAGIC]   = magic_det;
    src_lvl[SRC_PATTERN] = pattern_det;
    src_lvl[SRC_LINK]    = link_up;
  end

  assign pulse_unused = ^src_pulse;

  wake_evt_qual #(
    .N_SRC (NUM_SRC)
  ) u_qual (
    .clk       (clk),
    .rst       (rst),
    .src_lvl   (src_lvl),
    .mii_mode  (mii_mode),
    .src_pulse (src_pulse),
    .any_evt   (any_evt)
  );

  wake_pm_csr #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CSR_ADDR (CSR_ADDR),
    .EN_BIT   (EN_BIT),
    .ST_BIT   (ST_BIT)
  ) u_csr (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .evt       (any_evt),
    .cfg_rdata (cfg_rdata),
    .pme_en    (csr_en),
    .pme_st    (csr_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pme_n <= 1'b1;
    end else begin
      pme_n <= ~(csr_en & csr_st);
    end
  end

  // R1: request released after reset
  a_r1_pme_idle: assert property (@(posedge clk) rst |=> pme_n);

  // R8: a low request needs both bits one cycle earlier
  a_r8_low_needs_both: assert property (@(posedge clk) disable iff (rst)
    !pme_n |-> ($past(csr_en) && $past(csr_st)));

  // R8: dropping the enable releases the line on the next edge
  a_r8_release_on_disable: assert property (@(posedge clk) disable iff (rst)
    $fell(csr_en) |=> pme_n);

endmodule

// File: tb/wake_evt_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_evt_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        magic_det = 1'b0;
  logic        pattern_det = 1'b0;
  logic        link_up = 1'b0;
  logic        mii_mode = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [31:0] cfg_wdata = 32'h0;
  logic [31:0] cfg_rdata;
  logic        pme_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit rd_seen = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  wake_evt_ctrl dut_i (
    .clk(clk), .rst(rst), .magic_det(magic_det), .pattern_det(pattern_det),
    .link_up(link_up), .mii_mode(mii_mode), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pme_n(pme_n)
  );

  // Monitor: compares each read against the scoreboard entry
  always @(posedge clk) rd_seen <= cfg_rd;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (cfg_rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata=%h expected=%h", t, cfg_rdata, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    cyc(1);
    cfg_wr = 1'b0; cfg_wdata = 32'h0;
  endtask

  task automatic cfg_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    cfg_rd = 1'b1; cfg_addr = a;
    cyc(1);
    cfg_rd = 1'b0;
    cyc(1);
  endtask

  task automatic chk_pme(input logic e, input string t);
    checks++;
    if (pme_n !== e) begin
      fails++;
      $display("FAIL %s: pme_n=%b expected=%b", t, pme_n, e);
    end
  endtask

  localparam logic [31:0] EN = 32'h0000_0100;
  localparam logic [31:0] ST = 32'h0000_8000;

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk_pme(1'b1, "R1 pme idle");
    cfg_read(8'h44, 32'h0, "R1 csr after reset");

    // R2 enable write, other addresses
    cfg_write(8'h44, EN);
    cfg_read(8'h44, EN, "R2 enable readback");
    cfg_read(8'h40, 32'h0, "R2 other address reads 0");
    cfg_write(8'h40, 32'hFFFF_FFFF);
    cfg_write(8'h48, 32'h0000_0000);
    cfg_read(8'h44, EN, "R2 foreign writes ignored");

    // mii_mode = 0: pattern and link masked
    mii_mode = 1'b0; cyc(3);
    pattern_det = 1'b1; cyc(3); pattern_det = 1'b0; cyc(3);
    cfg_read(8'h44, EN, "R4 pattern masked in non-MII");
    chk_pme(1'b1, "R4 pme stays idle");
    link_up = 1'b1; cyc(3);
    cfg_read(8'h44, EN, "R5 link toggle masked in non-MII");

    // R3 magic in non-MII
    magic_det = 1'b1; cyc(3);
    chk_pme(1'b0, "R8 pme asserted");
    cfg_read(8'h44, EN | ST, "R3 magic sets status");
    cfg_write(8'h44, EN | ST);
    cyc(3);
    cfg_read(8'h44, EN, "R3 held level does not retrigger");
    chk_pme(1'b1, "R8 pme released after clear");
    magic_det = 1'b0; cyc(3);
    cfg_read(8'h44, EN, "R3 falling edge no event");

    // R6 sticky and write-0 no effect
    magic_det = 1'b1; cyc(3); magic_det = 1'b0; cyc(1);
    cfg_write(8'h44, EN);
    cyc(20);
    cfg_read(8'h44, EN | ST, "R6 bit15=0 write keeps status");
    chk_pme(1'b0, "R6 pme held");
    cfg_write(8'h44, EN | ST);
    cyc(2);
    cfg_read(8'h44, EN, "R6 write-1 clears");

    // MII mode: pattern and link honoured
    mii_mode = 1'b1; cyc(3);
    pattern_det = 1'b1; cyc(3); pattern_det = 1'b0;
    cfg_read(8'h44, EN | ST, "R4 pattern sets in MII");
    cfg_write(8'h44, EN | ST); cyc(2);
    link_up = 1'b0; cyc(3);
    cfg_read(8'h44, EN | ST, "R5 link down toggle sets");
    cfg_write(8'h44, EN | ST); cyc(2);
    link_up = 1'b1; cyc(3);
    cfg_read(8'h44, EN | ST, "R5 link up toggle sets");
    cfg_write(8'h44, EN | ST); cyc(2);
    magic_det = 1'b1; cyc(3); magic_det = 1'b0;
    cfg_read(8'h44, EN | ST, "R3 magic sets in MII");
    cfg_write(8'h44, EN | ST); cyc(2);

    // R8 masking by enable
    cfg_write(8'h44, 32'h0);
    magic_det = 1'b1; cyc(3); magic_det = 1'b0; cyc(1);
    chk_pme(1'b1, "R8 disabled pme stays high");
    cfg_read(8'h44, ST, "R8 status sets while disabled");
    cfg_write(8'h44, EN);
    cyc(1);
    chk_pme(1'b0, "R8 enable asserts pending request");
    cfg_write(8'h44, EN | ST); cyc(2);

    // R7 event and clear in the same cycle
    magic_det = 1'b1; cyc(3); magic_det = 1'b0; cyc(2);
    magic_det = 1'b1;
    cyc(1);
    cfg_write(8'h44, EN | ST);
    cyc(2);
    cfg_read(8'h44, EN | ST, "R7 event beats clear");
    magic_det = 1'b0;
    cfg_write(8'h44, EN | ST); cyc(2);
    cfg_read(8'h44, EN, "R7 later clear succeeds");

    // R1 reset mid-run
    cfg_write(8'h44, EN);
    magic_det = 1'b1; cyc(3); magic_det = 1'b0;
    rst = 1'b1; cyc(2); rst = 1'b0; cyc(1);
    chk_pme(1'b1, "R1 pme after second reset");
    cfg_read(8'h44, 32'h0, "R1 csr after second reset");

    cyc(4);
    if (exp_q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run not finished, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule